// File: doc/BRIEF.md
# Port-Filtered Fabric Traffic Counter

This block counts one kind of interconnect transaction at a time. The countable kinds are reads and writes on two host links, on a coherent link and on MMIO. Traffic reaches the block as a set of event lanes. In each cycle every lane may carry one transaction, given as a valid bit, a 3-bit event code and the 2-bit ID of the accelerator port that issued it. Software picks the event to count through a 64-bit control register. It also chooses whether to count that event across all ports or only for one selected port.

The result is read from a 64-bit counter register. That register holds a 60-bit running count and the event code currently in force. After changing the selection, software polls the counter register until the returned event code matches the new selection, and only then reads the count. The chosen filter mode and port stay in the control register and read back unchanged, so a restarted driver can recover the current mode. The count can be frozen, or cleared by a self-clearing bit. A build parameter removes the second host link and the coherent link from the countable set.

Top module: `fab_traffic_counter`

## Requirements
- R1: After reset the control register reads 0 and the counter register reads 0.
- R2: Control fields are freeze at bit 8, event select at bits 19:16, port ID at bits 21:20 and filter enable at bit 23. Each reads back as written. All other bits read 0, including the clear bit 0.
- R3: The counter register carries the count in bits 59:0 and the event select in force in bits 63:60. After a control write, the control readback shows the new select at once, while bits 63:60 show it one cycle later.
- R4: With the filter off, a lane counts when it is valid and its code equals the select, whatever its port tag. With the filter on, a lane also needs a port tag equal to the port ID field.
- R5: All matching lanes of one cycle add together in that cycle. The count grows by at most the lane count per cycle and wraps modulo 2^60.
- R6: A write that changes the select, the port ID or the filter enable clears the count, visible one cycle after the write. A write that changes only freeze keeps the count.
- R7: While freeze is 1 the count holds, and events arriving in that time are not counted.
- R8: Writing 1 to bit 0 clears the count even when freeze is set. The bit reads back as 0.
- R9: Select values 8 to 15 never count. With the link-set parameter at 0, select values 2 to 5 (second host link and coherent link, read/write) never count either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 64 | Control register write value |
| ctrl_rdata | output | 64 | Control register readback |
| cnt_rdata | output | 64 | Counter register: echoed select and count |
| ev_vld | input | NUM_LANES | Per-lane transaction valid |
| ev_code | input | NUM_LANES x 3 | Per-lane event code (0/1 host link 0 rd/wr, 2/3 host link 1 rd/wr, 4/5 coherent rd/wr, 6/7 MMIO rd/wr) |
| ev_port | input | NUM_LANES x 2 | Per-lane issuing port ID |

## Verification
Several properties are checked on every cycle. A frozen count stays still, a clear leaves zero behind, the echoed code follows a stable select, the count never steps by more than the lane count, and the filter passes nothing when no valid lane carries the selected port. The disabled link codes are also checked to produce no hits. Only the bench scenarios can show that the counted value is correct. The bench sweeps every select, port and filter combination against an arithmetic model, on both the full build and the reduced-link build. It also covers the one-cycle echo lag, and it shows that a freeze-only write keeps the count while a selection change clears it.

// File: rtl/fabcnt_pkg.sv
package fabcnt_pkg;

    localparam int REG_W   = 64;
    localparam int CNT_W   = 60;
    localparam int SEL_W   = 4;
    localparam int PORT_W  = 2;
    localparam int CODE_W  = 3;

    localparam int B_CLR   = 0;
    localparam int B_FRZ   = 8;
    localparam int B_SEL   = 16;
    localparam int B_PORT  = 20;
    localparam int B_FILT  = 23;

    typedef enum logic [SEL_W-1:0] {
        EV_LINK0_RD = 4'h0,
        EV_LINK0_WR = 4'h1,
        EV_LINK1_RD = 4'h2,
        EV_LINK1_WR = 4'h3,
        EV_COH_RD   = 4'h4,
        EV_COH_WR   = 4'h5,
        EV_MMIO_RD  = 4'h6,
        EV_MMIO_WR  = 4'h7
    } ev_kind_e;

    typedef struct packed {
        logic              filt_en;
        logic [PORT_W-1:0] port;
        logic [SEL_W-1:0]  sel;
        logic              freeze;
    } view_cfg_t;

    function automatic view_cfg_t cfg_from_word(input logic [REG_W-1:0] w);
        view_cfg_t c;
        c.filt_en = w[B_FILT];
        c.port    = w[B_PORT +: PORT_W];
        c.sel     = w[B_SEL +: SEL_W];
        c.freeze  = w[B_FRZ];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] word_from_cfg(input view_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_FILT]           = c.filt_en;
        w[B_PORT +: PORT_W] = c.port;
        w[B_SEL +: SEL_W]   = c.sel;
        w[B_FRZ]            = c.freeze;
        return w;
    endfunction

    // True when the counted stream differs between two settings.
    function automatic logic view_moved(input view_cfg_t a, input view_cfg_t b);
        return (a.sel != b.sel) || (a.port != b.port) || (a.filt_en != b.filt_en);
    endfunction

    // Whether a select value names a countable event in a given build.
    function automatic logic sel_countable(input logic [SEL_W-1:0] sel, input logic all_links);
        logic known;
        logic dropped;
        known   = (sel <= SEL_W'(EV_MMIO_WR));
        dropped = (sel >= SEL_W'(EV_LINK1_RD)) && (sel <= SEL_W'(EV_COH_WR));
        return known && (all_links || !dropped);
    endfunction

endpackage

// File: rtl/fabcnt_ctrl.sv
module fabcnt_ctrl
    import fabcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] ctrl_wdata,
    output view_cfg_t        cfg,
    output logic             clear,
    output logic [REG_W-1:0] ctrl_rdata
);

    view_cfg_t cfg_q;
    view_cfg_t cfg_nx;
    logic      clear_q;

    always_comb cfg_nx = cfg_from_word(ctrl_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            clear_q <= 1'b0;
        end else begin
            clear_q <= ctrl_we && (ctrl_wdata[B_CLR] || view_moved(cfg_nx, cfg_q));
            if (ctrl_we) begin
                cfg_q <= cfg_nx;
            end
        end
    end

    assign cfg        = cfg_q;
    assign clear      = clear_q;
    assign ctrl_rdata = word_from_cfg(cfg_q);

    // R2: settings move only on a write
    p_cfg_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(cfg_q));

    // R8: a written clear bit always yields a clear pulse
    p_clear_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_wdata[B_CLR]) |=> clear_q);

endmodule

// File: rtl/fabcnt_match.sv
module fabcnt_match
    import fabcnt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter bit ALL_LINKS = 1'b1,
    localparam int HIT_W    = $clog2(NUM_LANES + 1)
) (
    input  view_cfg_t                             cfg,
    input  logic [NUM_LANES-1:0]                  ev_vld,
    input  logic [NUM_LANES-1:0][CODE_W-1:0]      ev_code,
    input  logic [NUM_LANES-1:0][PORT_W-1:0]      ev_port,
    output logic [HIT_W-1:0]                      hits
);

    logic                 sel_ok;
    logic [NUM_LANES-1:0] lane_hit;

    assign sel_ok = sel_countable(cfg.sel, ALL_LINKS);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic code_eq;
        logic port_ok;
        assign code_eq     = (SEL_W'(ev_code[i]) == cfg.sel);
        assign port_ok     = !cfg.filt_en || (ev_port[i] == cfg.port);
        assign lane_hit[i] = ev_vld[i] && code_eq && port_ok && sel_ok;
    end

    always_comb begin
        hits = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            hits = hits + HIT_W'(lane_hit[i]);
        end
    end

    if (!ALL_LINKS) begin : g_reduced
        // R9: removed link codes never produce hits
        always_comb begin
            if ((cfg.sel >= SEL_W'(EV_LINK1_RD)) && (cfg.sel <= SEL_W'(EV_COH_WR))) begin
                p_link_off_r9: assert (hits == '0);
            end
        end
    end

endmodule

// File: rtl/fabcnt_accum.sv
module fabcnt_accum
    import fabcnt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    localparam int HIT_W    = $clog2(NUM_LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              freeze,
    input  logic [SEL_W-1:0]  sel,
    input  logic [HIT_W-1:0]  hits,
    output logic [CNT_W-1:0]  count,
    output logic [SEL_W-1:0]  echo
);

    logic [CNT_W-1:0] count_q;
    logic [SEL_W-1:0] echo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            echo_q  <= '0;
        end else begin
            echo_q <= sel;
            if (clear) begin
                count_q <= '0;
            end else if (!freeze) begin
                count_q <= count_q + CNT_W'(hits);
            end
        end
    end

    assign count = count_q;
    assign echo  = echo_q;

    // R7: frozen count does not move
    p_frozen_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (freeze && !clear) |=> (count_q == $past(count_q)));

    // R6: a clear leaves zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count_q == '0));

    // R3: echo settles on a select held for a cycle
    p_echo_follow_r3: assert property (@(posedge clk) disable iff (rst)
        $stable(sel) |-> (echo_q == sel));

    // R5: at most one step per lane each cycle
    p_step_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear && !freeze) |=> ((count_q - $past(count_q)) <= CNT_W'(NUM_LANES)));

endmodule

// File: rtl/fab_traffic_counter.sv
module fab_traffic_counter
    import fabcnt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter bit ALL_LINKS = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              ctrl_we,
    input  logic [63:0]                       ctrl_wdata,
    output logic [63:0]                       ctrl_rdata,
    output logic [63:0]                       cnt_rdata,
    input  logic [NUM_LANES-1:0]              ev_vld,
    input  logic [NUM_LANES-1:0][2:0]         ev_code,
    input  logic [NUM_LANES-1:0][1:0]         ev_port
);

    localparam int HIT_W = $clog2(NUM_LANES + 1);

    view_cfg_t        cfg;
    logic             clear;
    logic [HIT_W-1:0] hits;
    logic [CNT_W-1:0] count;
    logic [SEL_W-1:0] echo;
    logic             port_seen;

    fabcnt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .cfg        (cfg),
        .clear      (clear),
        .ctrl_rdata (ctrl_rdata)
    );

    fabcnt_match #(
        .NUM_LANES (NUM_LANES),
        .ALL_LINKS (ALL_LINKS)
    ) u_match (
        .cfg     (cfg),
        .ev_vld  (ev_vld),
        .ev_code (ev_code),
        .ev_port (ev_port),
        .hits    (hits)
    );

    fabcnt_accum #(
        .NUM_LANES (NUM_LANES)
    ) u_accum (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .freeze (cfg.freeze),
        .sel    (cfg.sel),
        .hits   (hits),
        .count  (count),
        .echo   (echo)
    );

    assign cnt_rdata = {echo, count};

    always_comb begin
        port_seen = 1'b0;
        for (int i = 0; i < NUM_LANES; i++) begin
            port_seen = port_seen || (ev_vld[i] && (ev_port[i] == cfg.port));
        end
    end

    // R4: filter passes nothing when no valid lane carries the chosen port
    p_filter_block_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.filt_en && !port_seen) |-> (hits == '0));

endmodule

// File: tb/tb_fab_traffic_counter.sv
module tb_fab_traffic_counter;

    localparam int CLK_PERIOD = 10;
    localparam int L          = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctrl_we = 1'b0;
    logic [63:0]       ctrl_wdata = '0;
    logic [63:0]       ctrl_rdata, ctrl_rdata_n;
    logic [63:0]       cnt_rdata, cnt_rdata_n;
    logic [L-1:0]      ev_vld = '0;
    logic [L-1:0][2:0] ev_code = '0;
    logic [L-1:0][1:0] ev_port = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fab_traffic_counter #(.NUM_LANES(L), .ALL_LINKS(1'b1)) dut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .cnt_rdata(cnt_rdata),
        .ev_vld(ev_vld), .ev_code(ev_code), .ev_port(ev_port));

    fab_traffic_counter #(.NUM_LANES(L), .ALL_LINKS(1'b0)) dut_nar (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata_n), .cnt_rdata(cnt_rdata_n),
        .ev_vld(ev_vld), .ev_code(ev_code), .ev_port(ev_port));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] cfg_word(input int s, input int p, input int f,
                                             input int frz, input int clr);
        logic [63:0] w;
        w = '0;
        w[19:16] = 4'(s);
        w[21:20] = 2'(p);
        w[23]    = f[0];
        w[8]     = frz[0];
        w[0]     = clr[0];
        return w;
    endfunction

    // write, then wait until the clear and the echo have taken effect
    task automatic wr(input logic [63:0] w);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w;
        @(negedge clk); ctrl_we = 1'b0;
        @(negedge clk);
    endtask

    // drive n lanes with one code for one cycle, ports 0..n-1
    task automatic burst(input int n, input int code);
        @(negedge clk);
        for (int l = 0; l < L; l++) begin
            ev_vld[l]  = (l < n);
            ev_code[l] = 3'(code);
            ev_port[l] = 2'(l);
        end
        @(negedge clk); ev_vld = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        longint exp_w, exp_n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ctrl reset", ctrl_rdata, 64'h0);
        chk("R1 counter reset", cnt_rdata, 64'h0);

        // R2: only the defined fields stick
        wr(64'hFFFF_FFFF_FFFF_FFFF);
        chk("R2 readback mask", ctrl_rdata, 64'h0000_0000_00BF_0100);

        // R5: three matches in one cycle
        wr(cfg_word(1, 0, 0, 0, 1));
        burst(3, 1);
        chk("R5 multi-lane add", cnt_rdata, {4'h1, 60'd3});

        // R3: echo lags the control readback by one cycle
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = cfg_word(6, 0, 0, 0, 0);
        @(negedge clk); ctrl_we = 1'b0;
        chk("R3 ctrl shows new select", 64'(ctrl_rdata[19:16]), 64'h6);
        chk("R3 echo still old", cnt_rdata, {4'h1, 60'd3});
        @(negedge clk);
        chk("R3 echo updated and R6 cleared", cnt_rdata, {4'h6, 60'd0});

        // R6/R7: freeze-only writes keep the count
        burst(2, 6);
        wr(cfg_word(6, 0, 0, 1, 0));
        chk("R6 freeze-only keeps count", cnt_rdata, {4'h6, 60'd2});
        burst(4, 6);
        chk("R7 frozen holds", cnt_rdata, {4'h6, 60'd2});
        wr(cfg_word(6, 0, 0, 0, 0));
        burst(1, 6);
        chk("R7 resumes after unfreeze", cnt_rdata, {4'h6, 60'd3});

        // R6: port/filter change clears
        wr(cfg_word(6, 2, 1, 0, 0));
        chk("R6 port change clears", cnt_rdata, {4'h6, 60'd0});
        burst(4, 6);
        chk("R4 filter keeps only port 2", cnt_rdata, {4'h6, 60'd1});

        // R8: clear bit wins over freeze and self-clears
        wr(cfg_word(6, 2, 1, 1, 1));
        chk("R8 clear under freeze", cnt_rdata, {4'h6, 60'd0});
        chk("R8 clear bit reads 0", ctrl_rdata, cfg_word(6, 2, 1, 1, 0));

        // R4/R5/R9: sweep every select, port and filter
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 16; s++) begin
                    wr(cfg_word(s, p, f, 0, 1));
                    chk("R2 sweep readback", ctrl_rdata, cfg_word(s, p, f, 0, 0));
                    exp_w = 0;
                    exp_n = 0;
                    for (int c = 0; c < 10; c++) begin
                        @(negedge clk);
                        for (int l = 0; l < L; l++) begin
                            bit v;
                            int cd, pt;
                            if (c < 2) begin
                                v  = 1'b1;
                                cd = s % 8;
                                pt = (c == 0) ? l : p;
                            end else begin
                                v  = ((c * 3 + l) % 4) != 0;
                                cd = (c * 5 + l * 3 + s) % 8;
                                pt = (c + l * 3) % 4;
                            end
                            ev_vld[l]  = v;
                            ev_code[l] = 3'(cd);
                            ev_port[l] = 2'(pt);
                            if (v && s < 8 && cd == s && (f == 0 || pt == p)) begin
                                exp_w++;
                                if (s < 2 || s > 5) exp_n++;
                            end
                        end
                    end
                    @(negedge clk); ev_vld = '0;
                    chk("R4 R5 R9 sweep full build", cnt_rdata, {4'(s), 60'(exp_w)});
                    chk("R9 sweep reduced build", cnt_rdata_n, {4'(s), 60'(exp_n)});
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule